// File: doc/BRIEF.md
# DMA Interrupt Status and Mask Unit

This unit gathers single-cycle event pulses from a packet DMA engine (completion of two receive rings, completion of four transmit rings, and one error pulse for each DMA direction) into a 32-bit sticky status register. A second 32-bit register holds one enable bit per source. The single interrupt line is high whenever any status bit is set and its enable bit is also set.

Software reads the status register to find pending events and clears them by writing ones back to the same bits. Status bits latch whether or not they are enabled. Enabling a pending source later raises the line as soon as the enable write takes effect. Register access uses a simple port: one address bit selects status (0) or mask (1), a write strobe commits the data on the clock edge, and read data follows the address combinationally.

Top module: `irq_stat_unit`

## Requirements
- R1: After reset, status reads 0, mask reads 0 and irq_o is low.
- R2: A pulse on rx_done_i[0] sets status bit 16, and a pulse on rx_done_i[1] sets bit 17, at the next clock edge.
- R3: A pulse on tx_done_i[n] (n = 0..3) sets status bit n at the next clock edge.
- R4: A pulse on tx_err_i sets status bit 29, and a pulse on rx_err_i sets status bit 31.
- R5: Writing the status register (address 0) clears each bit written as 1 and leaves each bit written as 0 unchanged. No write ever sets a status bit.
- R6: If an event pulse and a write-1 clear hit the same status bit in the same cycle, the bit ends up set.
- R7: The mask register (address 1) reads back what was written, and irq_o equals the OR over all bits of (status AND mask).
- R8: Status bits latch while masked. Writing the mask bit of a pending source raises irq_o right after that write's clock edge.
- R9: Bits other than 0–3, 16, 17, 29 and 31 read as zero in both registers and ignore writes (valid pattern 0xA003000F).
- R10: A status write leaves the mask unchanged, and a mask write leaves the status unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| reg_wr_i | input | 1 | Register write strobe |
| reg_addr_i | input | 1 | Register select: 0 status, 1 mask |
| reg_wdata_i | input | 32 | Write data |
| reg_rdata_o | output | 32 | Read data of the selected register |
| rx_done_i | input | 2 | Receive ring completion pulses |
| tx_done_i | input | 4 | Transmit ring completion pulses |
| tx_err_i | input | 1 | Transmit DMA error pulse |
| rx_err_i | input | 1 | Receive DMA error pulse |
| irq_o | output | 1 | Interrupt request |

## Verification
The assertions check on every cycle that a set request always wins over a clear, that an unrequested status bit never changes, that unused bits stay zero, that the mask only changes on a mask write, and that an enabled event raises the line one edge later. Only the bench scenarios can show the exact bit position that each source lands on, the read-back values through the register port, the isolation between the two registers, and the unmask-after-pending sequence. The bench sweeps all sources and all 32 bit positions.

// File: rtl/irq_pkg.sv
package irq_pkg;
  localparam int REG_W       = 32;
  localparam int TX_DONE_LSB = 0;
  localparam int RX_DONE_LSB = 16;
  localparam int TX_ERR_BIT  = 29;
  localparam int RX_ERR_BIT  = 31;

  localparam logic ADDR_STAT = 1'b0;
  localparam logic ADDR_MASK = 1'b1;

  function automatic logic [REG_W-1:0] valid_bits(input int nrx, input int ntx);
    logic [REG_W-1:0] v;
    v = '0;
    for (int i = 0; i < nrx; i++) v[RX_DONE_LSB+i] = 1'b1;
    for (int i = 0; i < ntx; i++) v[TX_DONE_LSB+i] = 1'b1;
    v[TX_ERR_BIT] = 1'b1;
    v[RX_ERR_BIT] = 1'b1;
    return v;
  endfunction
endpackage

// File: rtl/irq_event_map.sv
module irq_event_map #(
  parameter int NUM_RX = 2,
  parameter int NUM_TX = 4
) (
  input  logic [NUM_RX-1:0]          rx_done_i,
  input  logic [NUM_TX-1:0]          tx_done_i,
  input  logic                       tx_err_i,
  input  logic                       rx_err_i,
  output logic [irq_pkg::REG_W-1:0]  set_o
);
  import irq_pkg::*;

  logic [REG_W-1:0] rx_vec, tx_vec, err_vec;

  for (genvar g = 0; g < REG_W; g++) begin : g_map
    if (g >= RX_DONE_LSB && g < RX_DONE_LSB + NUM_RX) begin : g_rx
      assign rx_vec[g] = rx_done_i[g-RX_DONE_LSB];
    end else begin : g_rx0
      assign rx_vec[g] = 1'b0;
    end
    if (g >= TX_DONE_LSB && g < TX_DONE_LSB + NUM_TX) begin : g_tx
      assign tx_vec[g] = tx_done_i[g-TX_DONE_LSB];
    end else begin : g_tx0
      assign tx_vec[g] = 1'b0;
    end
    if (g == TX_ERR_BIT) begin : g_txe
      assign err_vec[g] = tx_err_i;
    end else if (g == RX_ERR_BIT) begin : g_rxe
      assign err_vec[g] = rx_err_i;
    end else begin : g_e0
      assign err_vec[g] = 1'b0;
    end
  end

  assign set_o = rx_vec | tx_vec | err_vec;
endmodule

// File: rtl/irq_status_reg.sv
module irq_status_reg #(
  parameter logic [irq_pkg::REG_W-1:0] VALID = '1
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic [irq_pkg::REG_W-1:0]  set_i,
  input  logic                       clr_en_i,
  input  logic [irq_pkg::REG_W-1:0]  clr_i,
  output logic [irq_pkg::REG_W-1:0]  stat_o
);
  import irq_pkg::*;

  logic [REG_W-1:0] stat_q, stat_d, clr_vec;

  assign clr_vec = clr_en_i ? clr_i : '0;
  // set applied after clear so a same-cycle event wins
  assign stat_d  = ((stat_q & ~clr_vec) | set_i) & VALID;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) stat_q <= '0;
    else         stat_q <= stat_d;
  end

  assign stat_o = stat_q;

  AST_SET_WINS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (set_i & VALID) != '0 |=> (stat_q & $past(set_i & VALID)) == $past(set_i & VALID)); // R6
  AST_CLEAR_TAKES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_en_i |=> (stat_q & $past(clr_i & ~set_i)) == '0); // R5
  AST_NO_SPURIOUS_SET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> (stat_q & ~$past(stat_q) & ~$past(set_i)) == '0); // R5
  AST_UNUSED_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stat_q & ~VALID) == '0); // R9
endmodule

// File: rtl/irq_mask_reg.sv
module irq_mask_reg #(
  parameter logic [irq_pkg::REG_W-1:0] VALID = '1
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       wr_i,
  input  logic [irq_pkg::REG_W-1:0]  wdata_i,
  output logic [irq_pkg::REG_W-1:0]  mask_o
);
  import irq_pkg::*;

  logic [REG_W-1:0] mask_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   mask_q <= '0;
    else if (wr_i) mask_q <= wdata_i & VALID;
  end

  assign mask_o = mask_q;

  AST_MASK_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_i |=> $stable(mask_q)); // R10
  AST_MASK_UNUSED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mask_q & ~VALID) == '0); // R9
endmodule

// File: rtl/irq_stat_unit.sv
module irq_stat_unit #(
  parameter int NUM_RX = 2,
  parameter int NUM_TX = 4
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       reg_wr_i,
  input  logic                       reg_addr_i,
  input  logic [irq_pkg::REG_W-1:0]  reg_wdata_i,
  output logic [irq_pkg::REG_W-1:0]  reg_rdata_o,
  input  logic [NUM_RX-1:0]          rx_done_i,
  input  logic [NUM_TX-1:0]          tx_done_i,
  input  logic                       tx_err_i,
  input  logic                       rx_err_i,
  output logic                       irq_o
);
  import irq_pkg::*;

  localparam logic [REG_W-1:0] VALID = valid_bits(NUM_RX, NUM_TX);

  logic [REG_W-1:0] set_vec, stat, mask;
  logic             wr_stat, wr_mask;

  assign wr_stat = reg_wr_i && (reg_addr_i == ADDR_STAT);
  assign wr_mask = reg_wr_i && (reg_addr_i == ADDR_MASK);

  irq_event_map #(.NUM_RX(NUM_RX), .NUM_TX(NUM_TX)) u_map (
    .rx_done_i (rx_done_i),
    .tx_done_i (tx_done_i),
    .tx_err_i  (tx_err_i),
    .rx_err_i  (rx_err_i),
    .set_o     (set_vec)
  );

  irq_status_reg #(.VALID(VALID)) u_stat (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .set_i    (set_vec),
    .clr_en_i (wr_stat),
    .clr_i    (reg_wdata_i),
    .stat_o   (stat)
  );

  irq_mask_reg #(.VALID(VALID)) u_mask (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .wr_i    (wr_mask),
    .wdata_i (reg_wdata_i),
    .mask_o  (mask)
  );

  assign reg_rdata_o = (reg_addr_i == ADDR_MASK) ? mask : stat;
  assign irq_o       = |(stat & mask);

  AST_IRQ_NEEDS_PENDING: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> stat != '0); // R7
  AST_ENABLED_EVENT_FIRES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((set_vec & mask) != '0) && !wr_mask |=> irq_o); // R8
  AST_UNMASK_PENDING_FIRES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_mask && ((stat & reg_wdata_i & ~(wr_stat ? reg_wdata_i : '0)) != '0) |=> irq_o); // R8
endmodule

// File: tb/irq_stat_unit_test.sv
module irq_stat_unit_test;
  localparam logic [31:0] VALID = 32'hA003_000F;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr = 1'b0;
  logic        addr = 1'b0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic [1:0]  rx_done = '0;
  logic [3:0]  tx_done = '0;
  logic        tx_err = 1'b0;
  logic        rx_err = 1'b0;
  logic        irq;

  int errors = 0;
  int checks = 0;

  always #5 clk = ~clk;

  irq_stat_unit uut (
    .clk_i(clk), .rst_ni(rst_n), .reg_wr_i(wr), .reg_addr_i(addr),
    .reg_wdata_i(wdata), .reg_rdata_o(rdata), .rx_done_i(rx_done),
    .tx_done_i(tx_done), .tx_err_i(tx_err), .rx_err_i(rx_err), .irq_o(irq)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%08h expected=%08h", req, act, exp);
    end
  endtask

  task automatic rd(input logic a, output logic [31:0] v);
    @(negedge clk);
    addr = a;
    #1 v = rdata;
  endtask

  task automatic wr_reg(input logic a, input logic [31:0] d);
    @(negedge clk);
    wr = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr = 1'b0; wdata = '0;
  endtask

  function automatic int src_pos(input int s);
    if (s < 2) return 16 + s;
    if (s < 6) return s - 2;
    if (s == 6) return 29;
    return 31;
  endfunction

  task automatic drive_src(input int s, input logic v);
    if (s < 2) rx_done[s] = v;
    else if (s < 6) tx_done[s-2] = v;
    else if (s == 6) tx_err = v;
    else rx_err = v;
  endtask

  task automatic pulse(input int s);
    @(negedge clk);
    drive_src(s, 1'b1);
    @(negedge clk);
    drive_src(s, 1'b0);
  endtask

  initial begin
    #(200000 * 10);
    errors++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [31:0] v;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    rd(1'b0, v); chk("R1 status", v, 32'h0);
    rd(1'b1, v); chk("R1 mask", v, 32'h0);
    chk("R1 irq", {31'b0, irq}, 32'h0);

    // per-source sweep: R2 R3 R4 positions, R8 latch while masked, R5 clear
    for (int s = 0; s < 8; s++) begin
      string tag;
      logic [31:0] bitv;
      tag = (s < 2) ? "R2" : (s < 6) ? "R3" : "R4";
      bitv = 32'h1 << src_pos(s);
      pulse(s);
      rd(1'b0, v); chk(tag, v, bitv);
      chk("R8 masked latch irq", {31'b0, irq}, 32'h0);
      wr_reg(1'b1, bitv);
      chk("R8 unmask pending irq", {31'b0, irq}, 32'h1);
      rd(1'b0, v); chk("R10 mask write keeps status", v, bitv);
      wr_reg(1'b0, ~bitv);
      rd(1'b0, v); chk("R5 write-0 keeps", v, bitv);
      wr_reg(1'b0, bitv);
      rd(1'b0, v); chk("R5 write-1 clears", v, 32'h0);
      chk("R7 irq drops", {31'b0, irq}, 32'h0);
      rd(1'b1, v); chk("R10 status write keeps mask", v, bitv);
      wr_reg(1'b1, 32'h0);
    end

    // R9 and R7: mask read-back per bit position
    for (int i = 0; i < 32; i++) begin
      wr_reg(1'b1, 32'h1 << i);
      rd(1'b1, v); chk("R9 R7 mask readback", v, (32'h1 << i) & VALID);
    end
    wr_reg(1'b1, 32'hFFFF_FFFF);
    rd(1'b1, v); chk("R9 mask all ones", v, VALID);

    // R5 R9: no write ever sets status
    wr_reg(1'b0, 32'hFFFF_FFFF);
    rd(1'b0, v); chk("R5 write cannot set", v, 32'h0);
    chk("R7 irq idle full mask", {31'b0, irq}, 32'h0);

    // all sources at once, then partial clear
    @(negedge clk);
    rx_done = '1; tx_done = '1; tx_err = 1'b1; rx_err = 1'b1;
    @(negedge clk);
    rx_done = '0; tx_done = '0; tx_err = 1'b0; rx_err = 1'b0;
    rd(1'b0, v); chk("R2 R3 R4 all sources", v, VALID);
    chk("R7 irq all", {31'b0, irq}, 32'h1);
    wr_reg(1'b0, 32'h2001_0005);
    rd(1'b0, v); chk("R5 partial clear", v, VALID & ~32'h2001_0005);

    // R7: mask off pending set, irq low; enable one pending bit
    wr_reg(1'b1, 32'h0000_0001);
    chk("R7 irq off disabled pending", {31'b0, irq}, 32'h0);
    wr_reg(1'b1, 32'h0002_0000);
    chk("R7 irq on enabled pending", {31'b0, irq}, 32'h1);
    wr_reg(1'b0, 32'hFFFF_FFFF);
    rd(1'b0, v); chk("R5 clear all", v, 32'h0);

    // R6 set wins over same-cycle clear, each source
    for (int s = 0; s < 8; s++) begin
      logic [31:0] bitv;
      bitv = 32'h1 << src_pos(s);
      pulse(s);
      @(negedge clk);
      wr = 1'b1; addr = 1'b0; wdata = bitv; drive_src(s, 1'b1);
      @(negedge clk);
      wr = 1'b0; wdata = '0; drive_src(s, 1'b0);
      rd(1'b0, v); chk("R6 set wins", v, bitv);
      wr_reg(1'b0, bitv);
      rd(1'b0, v); chk("R6 cleared after", v, 32'h0);
    end

    // R1 reset mid-run
    pulse(0);
    wr_reg(1'b1, 32'hFFFF_FFFF);
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk); rst_n = 1'b1;
    rd(1'b0, v); chk("R1 status after reset", v, 32'h0);
    rd(1'b1, v); chk("R1 mask after reset", v, 32'h0);
    chk("R1 irq after reset", {31'b0, irq}, 32'h0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule